// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

A single programmable down-counter channel. A fixed-rate count-enable pulse (nominally 1.193182 MHz, derived elsewhere from the system clock) advances it. The channel is told which of six behaviours to use when it is loaded: timeout, gate-triggered one-shot, rate generator, square wave, software strobe or hardware strobe. It receives an already-assembled initial count, an optional decimal counting select and a gate line. It drives its live count, an output pin and a flag that shows a freshly written count not yet taken into the counter.

A host-side decoder writes the mode, the decimal select and the count with a one-cycle `load` strobe. The value is moved into the counter on a later count-enable pulse. In the two triggered behaviours, that pulse must come after a rising gate edge. From then on the count enable paces everything. All inputs are synchronous to `clk`, and all outputs come straight from registers.

Top module: `interval_counter_channel`

## Requirements
- R1: After synchronous reset the count reads 0, the output pin is 1 and the loaded flag is 0.
- R2: A `load` strobe sets the loaded flag on the next edge and leaves the count unchanged, even when `cnt_en` is high in the same cycle. The output pin becomes 0 for mode code 0 and 1 for every other code. The flag clears on the count-enable pulse that copies the initial value into the counter. For codes 0, 2, 3 and 4 this is the first pulse after the load. For codes 1 and 5 it is the first pulse at or after a rising gate edge.
- R3: Code 0 (timeout): after the transfer, the count decrements on each pulse only while the gate is 1. The output goes to 1 on the pulse where the count steps from 1 to 0, and stays 1 as the count wraps.
- R4: Code 1 (triggered one-shot): the output stays 1 until a gate rise. A gate rise that falls between pulses is held until the next pulse. That pulse loads the count and drives the output to 0. Counting then continues whatever the gate does, and the output returns to 1 as the count steps from 1 to 0.
- R5: Code 2 (rate generator): the output is 0 for exactly the one pulse in which the count holds 1. The pulse after that reloads the initial value and sets the output to 1, so the period is N pulses.
- R6: Code 2: while the gate is 0 the count holds. On any clock edge where the gate is 0, the output is forced to 1.
- R7: Code 3 (square wave): the count steps down by 2 from the initial value with bit 0 cleared, and the output toggles at the end of each half period. For an even N the high and low halves are N/2 pulses each. For an odd N the high half is (N+1)/2 and the low half is (N-1)/2. The count never reads odd after the transfer.
- R8: Code 4 (software strobe): counting happens only while the gate is 1. The output drops to 0 for one pulse as the count steps from 1 to 0, and there is no reload and no second strobe.
- R9: Code 5 (hardware strobe): a gate rise, including one in the same cycle as a pulse, starts the countdown on that pulse. Counting ignores the gate afterwards. The output is 0 for one pulse as the count steps from 1 to 0.
- R10: With the decimal select at 1, the count is four BCD digits (bits 15:12 thousands down to 3:0 units) and decrements with decimal borrows, for example 0010 then 0009, and 0000 minus 2 gives 9998.
- R11: An initial count of 0 gives the longest period: 65536 pulses in binary, 10000 pulses in decimal.
- R12: Codes 6 and 7 behave exactly as codes 2 and 3.
- R13: Without a count-enable pulse the count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-enable pulse, one clock wide |
| load | input | 1 | Strobe that writes mode, decimal select and initial count |
| load_value | input | 16 | Initial count (binary or four BCD digits) |
| mode_sel | input | 3 | Operating mode code 0..7 |
| bcd_sel | input | 1 | 1 selects decimal counting |
| gate | input | 1 | Gate line, synchronous to clk |
| count_q | output | 16 | Live counter value |
| out_pin | output | 1 | Channel output |
| count_loaded | output | 1 | 1 while a written count awaits transfer |

## Verification
The bench targets the odd square-wave count. A design without the extra high pulse would give a symmetric wave, and the 5-pulse case shows that as a 2/2 split where 3/2 is expected. It applies a gate rise between pulses and a gate rise on a pulse cycle to the triggered modes. A trigger detector that only looks at the pulse cycle would leave the channel idle and the loaded flag stuck at 1. Full-length runs from a zero count in binary and in decimal check that the strobe arrives after exactly 65536 and 10000 pulses, which catches a counter that treats zero as an empty period or borrows wrongly across digits. A load coinciding with a pulse checks that the old count is not disturbed.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  typedef enum logic [2:0] {
    M_TIMEOUT      = 3'd0,
    M_TRIG_ONESHOT = 3'd1,
    M_RATE         = 3'd2,
    M_SQUARE       = 3'd3,
    M_SW_STROBE    = 3'd4,
    M_HW_STROBE    = 3'd5
  } op_mode_t;

  // codes 6 and 7 alias the periodic modes 2 and 3
  function automatic op_mode_t fold_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return op_mode_t'({1'b0, code[1:0]});
    return op_mode_t'(code);
  endfunction

endpackage

// File: rtl/ictr_step.sv
// Combinational decrement by one or two, binary or packed decimal.
module ictr_step #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] value,
  input  logic             step_two,
  input  logic             bcd,
  output logic [WIDTH-1:0] result
);
  localparam int DIGITS = WIDTH / 4;

  logic [WIDTH-1:0] bin_res;
  logic [WIDTH-1:0] dec_res;
  logic [DIGITS-1:0] borrow;

  assign bin_res = value - (step_two ? WIDTH'(2) : WIDTH'(1));

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [4:0] digit;
    logic [4:0] take;
    assign digit = {1'b0, value[4*g +: 4]};
    if (g == 0) begin : g_lsd
      assign take = step_two ? 5'd2 : 5'd1;
    end else begin : g_upper
      assign take = {4'd0, borrow[g-1]};
    end
    assign dec_res[4*g +: 4] = (digit < take) ? 4'(digit + 5'd10 - take)
                                              : 4'(digit - take);
    if (g < DIGITS - 1) begin : g_chain
      assign borrow[g] = digit < take;
    end else begin : g_top
      assign borrow[g] = 1'b0;
    end
  end

  assign result = bcd ? dec_res : bin_res;
endmodule

// File: rtl/ictr_trigger.sv
// Gate rising-edge detector; the edge is held until a count-enable pulse.
module ictr_trigger (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic consume,
  input  logic clear,
  output logic trig_now
);
  logic gate_d;
  logic trig_q;
  logic rise;

  assign rise     = gate & ~gate_d;
  assign trig_now = trig_q | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_d <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      gate_d <= gate;
      if (clear || consume) trig_q <= 1'b0;
      else if (rise)        trig_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ictr_core.sv
// Mode sequencing, counter register and output pin for one channel.
module ictr_core
  import ictr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_value,
  input  logic [2:0]       mode_code,
  input  logic             bcd_in,
  input  logic             gate,
  input  logic             tick,
  input  logic             trig_now,
  input  logic [WIDTH-1:0] dec_value,
  output logic             step_two,
  output logic             bcd_mode,
  output logic [WIDTH-1:0] count,
  output logic             out,
  output logic             pending
);
  localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] CNT_TWO = WIDTH'(2);

  op_mode_t         mode_q;
  logic [WIDTH-1:0] init_q;
  logic [WIDTH-1:0] init_even;
  logic             active_q;
  logic             fired_q;
  logic             stretch_q;
  op_mode_t         new_mode;

  assign new_mode  = fold_mode(mode_code);
  assign init_even = {init_q[WIDTH-1:1], 1'b0};
  assign step_two  = (mode_q == M_SQUARE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_TIMEOUT;
      bcd_mode  <= 1'b0;
      init_q    <= '0;
      count     <= '0;
      out       <= 1'b1;
      pending   <= 1'b0;
      active_q  <= 1'b0;
      fired_q   <= 1'b0;
      stretch_q <= 1'b0;
    end else if (load) begin
      mode_q    <= new_mode;
      bcd_mode  <= bcd_in;
      init_q    <= load_value;
      pending   <= 1'b1;
      active_q  <= 1'b0;
      fired_q   <= 1'b0;
      stretch_q <= 1'b0;
      out       <= (new_mode != M_TIMEOUT);
    end else begin
      if (mode_q == M_RATE && !gate) out <= 1'b1;
      if (tick) begin
        case (mode_q)
          M_TIMEOUT: begin
            if (pending) begin
              count    <= init_q;
              pending  <= 1'b0;
              active_q <= 1'b1;
            end else if (active_q && gate) begin
              count <= dec_value;
              if (count == CNT_ONE) out <= 1'b1;
            end
          end
          M_TRIG_ONESHOT: begin
            if (trig_now && (pending || active_q)) begin
              count    <= init_q;
              out      <= 1'b0;
              pending  <= 1'b0;
              active_q <= 1'b1;
            end else if (active_q) begin
              count <= dec_value;
              if (count == CNT_ONE) out <= 1'b1;
            end
          end
          M_RATE: begin
            if (pending) begin
              count    <= init_q;
              out      <= 1'b1;
              pending  <= 1'b0;
              active_q <= 1'b1;
            end else if (active_q && gate) begin
              if (count == CNT_ONE) begin
                count <= init_q;
                out   <= 1'b1;
              end else begin
                count <= dec_value;
                out   <= (count != CNT_TWO);
              end
            end
          end
          M_SQUARE: begin
            if (pending) begin
              count     <= init_even;
              out       <= 1'b1;
              stretch_q <= 1'b0;
              pending   <= 1'b0;
              active_q  <= 1'b1;
            end else if (active_q && gate) begin
              if (count == CNT_TWO) begin
                if (out && init_q[0] && !stretch_q) begin
                  stretch_q <= 1'b1;
                end else begin
                  out       <= ~out;
                  count     <= init_even;
                  stretch_q <= 1'b0;
                end
              end else begin
                count <= dec_value;
              end
            end
          end
          M_SW_STROBE: begin
            out <= 1'b1;
            if (pending) begin
              count    <= init_q;
              pending  <= 1'b0;
              active_q <= 1'b1;
            end else if (active_q && gate) begin
              count <= dec_value;
              if (count == CNT_ONE && !fired_q) begin
                out     <= 1'b0;
                fired_q <= 1'b1;
              end
            end
          end
          M_HW_STROBE: begin
            out <= 1'b1;
            if (trig_now && (pending || active_q)) begin
              count    <= init_q;
              pending  <= 1'b0;
              active_q <= 1'b1;
              fired_q  <= 1'b0;
            end else if (active_q) begin
              count <= dec_value;
              if (count == CNT_ONE && !fired_q) begin
                out     <= 1'b0;
                fired_q <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/interval_counter_channel.sv
module interval_counter_channel #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_value,
  input  logic [2:0]       mode_sel,
  input  logic             bcd_sel,
  input  logic             gate,
  output logic [WIDTH-1:0] count_q,
  output logic             out_pin,
  output logic             count_loaded
);
  logic [WIDTH-1:0] dec_value;
  logic             step_two;
  logic             bcd_mode;
  logic             trig_now;

  ictr_step #(.WIDTH(WIDTH)) u_step (
    .value    (count_q),
    .step_two (step_two),
    .bcd      (bcd_mode),
    .result   (dec_value)
  );

  ictr_trigger u_trig (
    .clk      (clk),
    .rst      (rst),
    .gate     (gate),
    .consume  (cnt_en),
    .clear    (load),
    .trig_now (trig_now)
  );

  ictr_core #(.WIDTH(WIDTH)) u_core (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_value (load_value),
    .mode_code  (mode_sel),
    .bcd_in     (bcd_sel),
    .gate       (gate),
    .tick       (cnt_en),
    .trig_now   (trig_now),
    .dec_value  (dec_value),
    .step_two   (step_two),
    .bcd_mode   (bcd_mode),
    .count      (count_q),
    .out        (out_pin),
    .pending    (count_loaded)
  );
endmodule

// File: rtl/ictr_chk.sv
module ictr_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             load,
  input logic [2:0]       mode_sel,
  input logic             gate,
  input logic [WIDTH-1:0] count_q,
  input logic             out_pin,
  input logic             count_loaded
);
  logic [2:0] mode_seen;
  logic       is_rate;
  logic       is_square;

  always_ff @(posedge clk) begin
    if (rst)       mode_seen <= 3'd0;
    else if (load) mode_seen <= mode_sel;
  end

  assign is_rate   = (mode_seen == 3'd2) || (mode_seen == 3'd6);
  assign is_square = (mode_seen == 3'd3) || (mode_seen == 3'd7);

  // R2
  load_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> count_loaded);

  // R2
  flag_clears_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(count_loaded) |-> $past(cnt_en));

  // R13
  hold_without_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count_q));

  // R6
  rate_gate_low_high_chk: assert property (@(posedge clk) disable iff (rst)
    (is_rate && !load && !gate) |=> out_pin);

  // R3
  timeout_never_falls_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_seen == 3'd0 && !load) |=> !$fell(out_pin));

  // R7
  square_count_even_chk: assert property (@(posedge clk) disable iff (rst)
    (is_square && !count_loaded) |-> !count_q[0]);
endmodule

bind interval_counter_channel ictr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cnt_en       (cnt_en),
  .load         (load),
  .mode_sel     (mode_sel),
  .gate         (gate),
  .count_q      (count_q),
  .out_pin      (out_pin),
  .count_loaded (count_loaded)
);

// File: tb/test_interval_counter_channel.sv
`timescale 1ns/1ps
module test_interval_counter_channel;
  localparam int W = 16;
  localparam logic [2:0] ALL = 3'b111;
  localparam logic [2:0] OUT_LD = 3'b110;

  logic clk = 1'b0, rst = 1'b1, cnt_en = 1'b0, load = 1'b0, bcd_sel = 1'b0, gate = 1'b0;
  logic [2:0]   mode_sel = 3'd0;
  logic [W-1:0] load_value = '0;
  logic [W-1:0] count_q;
  logic         out_pin, count_loaded;

  typedef struct {
    logic [15:0] cnt;
    logic        out;
    logic        ld;
    logic [2:0]  mask;
    string       req;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  interval_counter_channel #(.WIDTH(W)) i_interval_counter_channel (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load(load), .load_value(load_value),
    .mode_sel(mode_sel), .bcd_sel(bcd_sel), .gate(gate),
    .count_q(count_q), .out_pin(out_pin), .count_loaded(count_loaded));

  function automatic logic [15:0] to_bcd(input int n);
    return {4'(n / 1000 % 10), 4'(n / 100 % 10), 4'(n / 10 % 10), 4'(n % 10)};
  endfunction

  // drive one cycle and queue the state expected after its edge
  task automatic cyc(input logic en, input logic g, input logic [2:0] m,
                     input logic [15:0] c, input logic o, input logic l, input string r);
    @(negedge clk); #1;
    cnt_en = en; gate = g; load = 1'b0;
    sb.push_back('{c, o, l, m, r});
  endtask

  task automatic write_count(input logic [2:0] md, input logic b, input logic [15:0] v,
                             input logic en, input logic g, input logic o, input string r);
    @(negedge clk); #1;
    cnt_en = en; gate = g; load = 1'b1; mode_sel = md; bcd_sel = b; load_value = v;
    sb.push_back('{16'h0, o, 1'b1, OUT_LD, r});
  endtask

  // monitor: compare one queued item per cycle, away from the active edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        if (e.mask != 3'b000) begin
          checks++;
          if ((e.mask[0] && count_q !== e.cnt) || (e.mask[1] && out_pin !== e.out) ||
              (e.mask[2] && count_loaded !== e.ld)) begin
            errors++;
            $display("FAIL %s: count=%h out=%b loaded=%b expected count=%h out=%b loaded=%b (mask %b)",
                     e.req, count_q, out_pin, count_loaded, e.cnt, e.out, e.ld, e.mask);
          end
        end
      end
    end
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cyc(0, 0, ALL, 16'h0, 1, 0, "R1");

    // R3 timeout, N=3, with R2 flag and R13 hold
    write_count(3'd0, 0, 16'd3, 0, 1, 0, "R2");
    cyc(0, 1, ALL, 16'h0, 0, 1, "R2");
    cyc(1, 1, ALL, 16'd3, 0, 0, "R3");
    cyc(1, 1, ALL, 16'd2, 0, 0, "R3");
    cyc(1, 1, ALL, 16'd1, 0, 0, "R3");
    cyc(0, 1, ALL, 16'd1, 0, 0, "R13");
    cyc(1, 0, ALL, 16'd1, 0, 0, "R3");
    cyc(1, 1, ALL, 16'd0, 1, 0, "R3");
    cyc(1, 1, ALL, 16'hFFFF, 1, 0, "R3");
    // R2 load on a pulse cycle leaves count untouched
    write_count(3'd0, 0, 16'd5, 1, 1, 0, "R2");
    cyc(0, 1, ALL, 16'hFFFF, 0, 1, "R2");
    cyc(1, 1, ALL, 16'd5, 0, 0, "R2");

    // R4 triggered one-shot, gate rise between pulses
    write_count(3'd1, 0, 16'd2, 0, 0, 1, "R4");
    cyc(1, 0, ALL, 16'd5, 1, 1, "R4");
    cyc(0, 1, ALL, 16'd5, 1, 1, "R4");
    cyc(1, 0, ALL, 16'd2, 0, 0, "R4");
    cyc(1, 0, ALL, 16'd1, 0, 0, "R4");
    cyc(1, 0, ALL, 16'd0, 1, 0, "R4");
    cyc(1, 0, ALL, 16'hFFFF, 1, 0, "R4");

    // R5 rate generator N=3, R6 gate low
    write_count(3'd2, 0, 16'd3, 0, 1, 1, "R5");
    cyc(1, 1, ALL, 16'd3, 1, 0, "R5");
    cyc(1, 1, ALL, 16'd2, 1, 0, "R5");
    cyc(1, 1, ALL, 16'd1, 0, 0, "R5");
    cyc(1, 1, ALL, 16'd3, 1, 0, "R5");
    cyc(1, 1, ALL, 16'd2, 1, 0, "R5");
    cyc(1, 1, ALL, 16'd1, 0, 0, "R5");
    cyc(0, 0, ALL, 16'd1, 1, 0, "R6");
    cyc(1, 0, ALL, 16'd1, 1, 0, "R6");
    cyc(1, 1, ALL, 16'd3, 1, 0, "R6");

    // R7 square wave odd N=5: high 3, low 2
    write_count(3'd3, 0, 16'd5, 0, 1, 1, "R7");
    cyc(1, 1, ALL, 16'd4, 1, 0, "R7");
    cyc(1, 1, ALL, 16'd2, 1, 0, "R7");
    cyc(1, 1, ALL, 16'd2, 1, 0, "R7");
    cyc(1, 1, ALL, 16'd4, 0, 0, "R7");
    cyc(1, 1, ALL, 16'd2, 0, 0, "R7");
    cyc(1, 1, ALL, 16'd4, 1, 0, "R7");

    // R12 code 7 as square wave, even N=4: high 2, low 2
    write_count(3'd7, 0, 16'd4, 0, 1, 1, "R12");
    cyc(1, 1, ALL, 16'd4, 1, 0, "R12");
    cyc(1, 1, ALL, 16'd2, 1, 0, "R12");
    cyc(1, 1, ALL, 16'd4, 0, 0, "R12");
    cyc(1, 1, ALL, 16'd2, 0, 0, "R12");
    cyc(1, 1, ALL, 16'd4, 1, 0, "R12");
    // R12 code 6 as rate generator
    write_count(3'd6, 0, 16'd2, 0, 1, 1, "R12");
    cyc(1, 1, ALL, 16'd2, 1, 0, "R12");
    cyc(1, 1, ALL, 16'd1, 0, 0, "R12");
    cyc(1, 1, ALL, 16'd2, 1, 0, "R12");

    // R8 software strobe
    write_count(3'd4, 0, 16'd2, 0, 1, 1, "R8");
    cyc(1, 1, ALL, 16'd2, 1, 0, "R8");
    cyc(1, 0, ALL, 16'd2, 1, 0, "R8");
    cyc(1, 1, ALL, 16'd1, 1, 0, "R8");
    cyc(1, 1, ALL, 16'd0, 0, 0, "R8");
    cyc(1, 1, ALL, 16'hFFFF, 1, 0, "R8");
    cyc(1, 1, ALL, 16'hFFFE, 1, 0, "R8");

    // R9 hardware strobe, gate rise on a pulse cycle
    write_count(3'd5, 0, 16'd2, 0, 0, 1, "R9");
    cyc(1, 0, ALL, 16'hFFFE, 1, 1, "R9");
    cyc(1, 1, ALL, 16'd2, 1, 0, "R9");
    cyc(1, 0, ALL, 16'd1, 1, 0, "R9");
    cyc(1, 0, ALL, 16'd0, 0, 0, "R9");
    cyc(1, 0, ALL, 16'hFFFF, 1, 0, "R9");

    // R10 decimal borrow
    write_count(3'd0, 1, 16'h0010, 0, 1, 0, "R10");
    cyc(1, 1, ALL, 16'h0010, 0, 0, "R10");
    cyc(1, 1, ALL, 16'h0009, 0, 0, "R10");
    cyc(1, 1, ALL, 16'h0008, 0, 0, "R10");
    write_count(3'd3, 1, 16'h0000, 0, 1, 1, "R10");
    cyc(1, 1, ALL, 16'h0000, 1, 0, "R10");
    cyc(1, 1, ALL, 16'h9998, 1, 0, "R10");

    // R11 zero count: 65536-pulse binary period
    write_count(3'd2, 0, 16'h0000, 0, 1, 1, "R11");
    cyc(1, 1, ALL, 16'h0000, 1, 0, "R11");
    for (int k = 1; k <= 65536; k++)
      cyc(1, 1, ALL, 16'(65536 - k), (k == 65535) ? 1'b0 : 1'b1, 0, "R11");

    // R11 zero count: 10000-pulse decimal period
    write_count(3'd2, 1, 16'h0000, 0, 1, 1, "R11");
    cyc(1, 1, ALL, 16'h0000, 1, 0, "R11");
    for (int k = 1; k <= 10000; k++)
      cyc(1, 1, ALL, to_bcd((10000 - k) % 10000), (k == 9999) ? 1'b0 : 1'b1, 0, "R11");

    cyc(0, 1, 3'b000, 16'h0, 0, 0, "idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule